// File: doc/BRIEF.md
# Four-Lane Vector ALU with Cross-Lane Reduction

This execution unit works on 128-bit vectors that it treats as four independent 32-bit lanes. One operation code picks the function. The lane-wise functions (add, nand, multiply, xor) combine two vector operands lane by lane. A horizontal reduction adds all four lanes of one vector into a single 32-bit scalar. Two kinds of transfer move data between the scalar and vector domains: pack builds a vector from four scalar words, and unpack returns either the low or the high pair of lanes as two scalars.

The unit sits between operand read and result write-back in a vector datapath. It reports which destinations the current operation writes: a vector result, one scalar result, or two scalar results. Register files, memory and instruction decoding sit outside the block. The datapath is combinational. A parameter can add one output register stage with synchronous active-high reset.

Top module: `vec_alu_unit`

## Requirements
- R1: With op code 0 (lane add), each 32-bit lane of the vector result is the sum of the same lanes of operands A and B, truncated to 32 bits, with no carry into the neighbouring lane.
- R2: With op code 1 (lane nand), each lane of the vector result is the bitwise inverse of the AND of the matching lanes of A and B.
- R3: With op code 2 (lane multiply), each lane of the vector result is the low 32 bits of the product of the matching lanes of A and B.
- R4: With op code 3 (lane xor), each lane of the vector result is the bitwise XOR of the matching lanes of A and B.
- R5: With op code 4 (reduce), scalar result 0 is the sum of all four lanes of operand A, modulo 2^32.
- R6: With op code 5 (pack), vector lane k equals scalar input word k (bits 32k+31 down to 32k of the scalar bus), for k = 0 to 3.
- R7: With op code 6 (unpack low), scalar result 0 is lane 0 of A and scalar result 1 is lane 1 of A.
- R8: With op code 7 (unpack high), scalar result 0 is lane 2 of A and scalar result 1 is lane 3 of A.
- R9: Write enables come as {vector, scalar 0, scalar 1}: 100 for op codes 0 to 3 and 5, 010 for op code 4, and 011 for op codes 6 and 7.
- R10: While the valid input is low, all write enables and all results are zero.
- R11: With the output register present, results and enables appear one clock after the inputs, and a cycle with reset high clears them all to zero. Without it, they follow the inputs in the same cycle.
- R12: Any result that the current operation does not write reads as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst | input | 1 | Synchronous active-high reset of the output register |
| op_valid_i | input | 1 | Operation present this cycle |
| op_i | input | 3 | Operation code (0 to 7) |
| va_i | input | 128 | Vector operand A, lane k in bits 32k+31:32k |
| vb_i | input | 128 | Vector operand B |
| scal_i | input | 128 | Four scalar words for pack, word k in bits 32k+31:32k |
| vres_o | output | 128 | Vector result |
| sres0_o | output | 32 | Scalar result 0 |
| sres1_o | output | 32 | Scalar result 1 |
| vwe_o | output | 1 | Vector result write enable |
| swe0_o | output | 1 | Scalar result 0 write enable |
| swe1_o | output | 1 | Scalar result 1 write enable |

## Verification
The bench builds two copies with the default four 32-bit lanes. One has the output register (REG_OUT=1) and the other is purely combinational (REG_OUT=0), and both get the same stimulus. This exercises the one-cycle latency and the reset clearing of the registered variant. It also shows that the unregistered variant tracks its inputs inside the cycle, which is how a change in the inputs is seen not to disturb the registered outputs before the edge. The table covers lane overflow with no carry between lanes, product truncation, a reduction that wraps, and both unpack halves.

// File: rtl/valu_pkg.sv
package valu_pkg;

    localparam int LANE_W = 32;
    localparam int LANES  = 4;
    localparam int VEC_W  = LANE_W * LANES;
    localparam int OP_W   = 3;
    localparam int HI_LANE = LANES / 2;

    typedef enum logic [OP_W-1:0] {
        OP_VADD  = 3'd0,
        OP_VNAND = 3'd1,
        OP_VMUL  = 3'd2,
        OP_VXOR  = 3'd3,
        OP_VSUM  = 3'd4,
        OP_PACK  = 3'd5,
        OP_UNLO  = 3'd6,
        OP_UNHI  = 3'd7
    } vop_e;

    typedef logic [LANE_W-1:0] word_t;
    typedef logic [VEC_W-1:0]  vec_t;

    typedef struct packed {
        vec_t  vec;
        word_t s0;
        word_t s1;
        logic  vwe;
        logic  swe0;
        logic  swe1;
    } vout_t;

    function automatic logic is_lanewise(vop_e op);
        return (op == OP_VADD) || (op == OP_VNAND) ||
               (op == OP_VMUL) || (op == OP_VXOR);
    endfunction

endpackage

// File: rtl/valu_lanewise.sv
module valu_lanewise
    import valu_pkg::*;
(
    input  vop_e op,
    input  vec_t a,
    input  vec_t b,
    output vec_t y
);

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        word_t wa, wb, wy;
        assign wa = a[g*LANE_W +: LANE_W];
        assign wb = b[g*LANE_W +: LANE_W];

        always_comb begin
            case (op)
                OP_VADD:  wy = wa + wb;
                OP_VNAND: wy = ~(wa & wb);
                OP_VMUL:  wy = wa * wb;
                OP_VXOR:  wy = wa ^ wb;
                default:  wy = '0;
            endcase
        end

        assign y[g*LANE_W +: LANE_W] = wy;
    end

endmodule

// File: rtl/valu_reduce.sv
module valu_reduce
    import valu_pkg::*;
(
    input  vec_t  a,
    output word_t sum
);

    always_comb begin
        sum = '0;
        for (int k = 0; k < LANES; k++) begin
            sum = sum + a[k*LANE_W +: LANE_W];
        end
    end

endmodule

// File: rtl/valu_xfer.sv
module valu_xfer
    import valu_pkg::*;
(
    input  vop_e  op,
    input  vec_t  a,
    input  vec_t  scal,
    output vec_t  packed_v,
    output word_t pair0,
    output word_t pair1
);

    // scalar word k lands in lane k
    for (genvar g = 0; g < LANES; g++) begin : g_pack
        assign packed_v[g*LANE_W +: LANE_W] = scal[g*LANE_W +: LANE_W];
    end

    always_comb begin
        if (op == OP_UNHI) begin
            pair0 = a[HI_LANE*LANE_W       +: LANE_W];
            pair1 = a[(HI_LANE + 1)*LANE_W +: LANE_W];
        end else begin
            pair0 = a[0      +: LANE_W];
            pair1 = a[LANE_W +: LANE_W];
        end
    end

endmodule

// File: rtl/valu_outstage.sv
module valu_outstage
    import valu_pkg::*;
#(
    parameter bit REG_OUT = 1'b1
) (
    input  logic  clk,
    input  logic  rst,
    input  vout_t d,
    output vout_t q
);

    if (REG_OUT) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst) q <= '0;
            else     q <= d;
        end
    end else begin : g_pass
        assign q = d;
    end

endmodule

// File: rtl/vec_alu_unit.sv
module vec_alu_unit
    import valu_pkg::*;
#(
    parameter bit REG_OUT = 1'b1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               op_valid_i,
    input  logic [OP_W-1:0]    op_i,
    input  logic [VEC_W-1:0]   va_i,
    input  logic [VEC_W-1:0]   vb_i,
    input  logic [VEC_W-1:0]   scal_i,
    output logic [VEC_W-1:0]   vres_o,
    output logic [LANE_W-1:0]  sres0_o,
    output logic [LANE_W-1:0]  sres1_o,
    output logic               vwe_o,
    output logic               swe0_o,
    output logic               swe1_o
);

    vop_e  op;
    vec_t  lw_y, pk_v;
    word_t red_s, pr0, pr1;
    vout_t nxt, cur;

    assign op = vop_e'(op_i);

    valu_lanewise u_lw  (.op(op), .a(va_i), .b(vb_i), .y(lw_y));
    valu_reduce   u_red (.a(va_i), .sum(red_s));
    valu_xfer     u_xf  (.op(op), .a(va_i), .scal(scal_i),
                         .packed_v(pk_v), .pair0(pr0), .pair1(pr1));

    always_comb begin
        nxt = '0;
        if (op_valid_i) begin
            if (is_lanewise(op)) begin
                nxt.vec = lw_y;
                nxt.vwe = 1'b1;
            end else begin
                case (op)
                    OP_VSUM: begin
                        nxt.s0   = red_s;
                        nxt.swe0 = 1'b1;
                    end
                    OP_PACK: begin
                        nxt.vec = pk_v;
                        nxt.vwe = 1'b1;
                    end
                    default: begin
                        nxt.s0   = pr0;
                        nxt.s1   = pr1;
                        nxt.swe0 = 1'b1;
                        nxt.swe1 = 1'b1;
                    end
                endcase
            end
        end
    end

    valu_outstage #(.REG_OUT(REG_OUT)) u_out (.clk(clk), .rst(rst), .d(nxt), .q(cur));

    assign vres_o  = cur.vec;
    assign sres0_o = cur.s0;
    assign sres1_o = cur.s1;
    assign vwe_o   = cur.vwe;
    assign swe0_o  = cur.swe0;
    assign swe1_o  = cur.swe1;

endmodule

// File: rtl/vec_alu_unit_chk.sv
module vec_alu_unit_chk
    import valu_pkg::*;
#(
    parameter bit REG_OUT = 1'b1
) (
    input logic              clk,
    input logic              rst,
    input logic              op_valid_i,
    input logic [OP_W-1:0]   op_i,
    input logic [VEC_W-1:0]  va_i,
    input logic [VEC_W-1:0]  vb_i,
    input logic [VEC_W-1:0]  scal_i,
    input logic [VEC_W-1:0]  vres_o,
    input logic [LANE_W-1:0] sres0_o,
    input logic [LANE_W-1:0] sres1_o,
    input logic              vwe_o,
    input logic              swe0_o,
    input logic              swe1_o
);

    // inputs aligned to the cycle in which their results show
    logic             s_valid;
    logic [OP_W-1:0]  s_op;
    logic [VEC_W-1:0] s_va, s_vb, s_sc;

    if (REG_OUT) begin : g_dly
        always_ff @(posedge clk) begin
            if (rst) begin
                s_valid <= 1'b0;
                s_op    <= '0;
                s_va    <= '0;
                s_vb    <= '0;
                s_sc    <= '0;
            end else begin
                s_valid <= op_valid_i;
                s_op    <= op_i;
                s_va    <= va_i;
                s_vb    <= vb_i;
                s_sc    <= scal_i;
            end
        end
    end else begin : g_now
        assign s_valid = op_valid_i;
        assign s_op    = op_i;
        assign s_va    = va_i;
        assign s_vb    = vb_i;
        assign s_sc    = scal_i;
    end

    a_r1_add_low_lane: assert property (@(posedge clk) disable iff (rst)
        (s_valid && s_op == OP_VADD) |->
            (vres_o[LANE_W-1:0] == LANE_W'(s_va[LANE_W-1:0] + s_vb[LANE_W-1:0])));

    a_r5_sum_scalar_only: assert property (@(posedge clk) disable iff (rst)
        (s_valid && s_op == OP_VSUM) |-> (swe0_o && !vwe_o && !swe1_o));

    a_r6_pack_order: assert property (@(posedge clk) disable iff (rst)
        (s_valid && s_op == OP_PACK) |-> (vres_o == s_sc && vwe_o));

    a_r8_high_pair: assert property (@(posedge clk) disable iff (rst)
        (s_valid && s_op == OP_UNHI) |->
            (sres0_o == s_va[2*LANE_W +: LANE_W] && sres1_o == s_va[3*LANE_W +: LANE_W]));

    a_r9_vec_or_scalar: assert property (@(posedge clk) disable iff (rst)
        $onehot0({vwe_o, swe0_o}));

    a_r9_pair_needs_first: assert property (@(posedge clk) disable iff (rst)
        swe1_o |-> swe0_o);

    a_r10_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        !s_valid |-> (!vwe_o && !swe0_o && !swe1_o));

endmodule

bind vec_alu_unit vec_alu_unit_chk #(.REG_OUT(REG_OUT)) u_chk (
    .clk(clk), .rst(rst), .op_valid_i(op_valid_i), .op_i(op_i),
    .va_i(va_i), .vb_i(vb_i), .scal_i(scal_i),
    .vres_o(vres_o), .sres0_o(sres0_o), .sres1_o(sres1_o),
    .vwe_o(vwe_o), .swe0_o(swe0_o), .swe1_o(swe1_o)
);

// File: tb/sim_vec_alu_unit.sv
module sim_vec_alu_unit;

    localparam int CLK_PERIOD = 10;
    localparam int W  = 32;
    localparam int NL = 4;
    localparam int VW = W * NL;
    localparam int EW = 3 + 3*VW + 3;
    localparam int NV = 10;

    // {op, A, B, scalars, expected enables {vec, s0, s1}}
    localparam logic [EW-1:0] TBL [NV] = '{
        {3'd0, 128'hffffffff_7fffffff_00000001_12345678, 128'h00000001_00000001_ffffffff_11111111, 128'h0, 3'b100},
        {3'd1, 128'hffff0000_aaaaaaaa_00000000_ffffffff, 128'h0f0f0f0f_55555555_00000000_ffffffff, 128'h0, 3'b100},
        {3'd2, 128'h00010000_ffffffff_00000003_80000000, 128'h00010000_ffffffff_00000007_00000002, 128'h0, 3'b100},
        {3'd3, 128'h12345678_9abcdef0_00000000_ffffffff, 128'h87654321_0fedcba9_ffffffff_ffffffff, 128'h0, 3'b100},
        {3'd4, 128'hffffffff_ffffffff_ffffffff_ffffffff, 128'h1, 128'h5, 3'b010},
        {3'd4, 128'h00000004_00000003_00000002_00000001, 128'h9, 128'h0, 3'b010},
        {3'd5, 128'h01010101_02020202_03030303_04040404, 128'h7, 128'hdddddddd_cccccccc_bbbbbbbb_aaaaaaaa, 3'b100},
        {3'd6, 128'h44444444_33333333_22222222_11111111, 128'h3, 128'h8, 3'b011},
        {3'd7, 128'h44444444_33333333_22222222_11111111, 128'h3, 128'h8, 3'b011},
        {3'd0, 128'h0, 128'h0, 128'hffffffff_ffffffff_ffffffff_ffffffff, 3'b100}
    };

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          vld = 1'b0;
    logic [2:0]    op  = '0;
    logic [VW-1:0] va = '0, vb = '0, sc = '0;

    logic [VW-1:0] r0_v, r1_v;
    logic [W-1:0]  r0_s0, r0_s1, r1_s0, r1_s1;
    logic          r0_vwe, r0_swe0, r0_swe1, r1_vwe, r1_swe0, r1_swe1;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    vec_alu_unit #(.REG_OUT(1'b1)) u0 (
        .clk(clk), .rst(rst), .op_valid_i(vld), .op_i(op),
        .va_i(va), .vb_i(vb), .scal_i(sc),
        .vres_o(r0_v), .sres0_o(r0_s0), .sres1_o(r0_s1),
        .vwe_o(r0_vwe), .swe0_o(r0_swe0), .swe1_o(r0_swe1));

    vec_alu_unit #(.REG_OUT(1'b0)) u1 (
        .clk(clk), .rst(rst), .op_valid_i(vld), .op_i(op),
        .va_i(va), .vb_i(vb), .scal_i(sc),
        .vres_o(r1_v), .sres0_o(r1_s0), .sres1_o(r1_s1),
        .vwe_o(r1_vwe), .swe0_o(r1_swe0), .swe1_o(r1_swe1));

    typedef struct packed {
        logic [VW-1:0] v;
        logic [W-1:0]  s0;
        logic [W-1:0]  s1;
    } res_t;

    // reference computed from the requirements
    function automatic res_t model(logic [2:0] o, logic [VW-1:0] a, logic [VW-1:0] b, logic [VW-1:0] s);
        res_t r = '0;
        logic [W-1:0] x, y;
        logic [63:0]  p;
        for (int k = 0; k < NL; k++) begin
            x = a[k*W +: W];
            y = b[k*W +: W];
            p = 64'(x) * 64'(y);
            case (o)
                3'd0: r.v[k*W +: W] = x + y;
                3'd1: r.v[k*W +: W] = ~(x & y);
                3'd2: r.v[k*W +: W] = p[W-1:0];
                3'd3: r.v[k*W +: W] = x ^ y;
                3'd4: r.s0 = r.s0 + x;
                3'd5: r.v[k*W +: W] = s[k*W +: W];
                default: ;
            endcase
        end
        if (o == 3'd6) begin r.s0 = a[0 +: W];   r.s1 = a[W +: W];   end
        if (o == 3'd7) begin r.s0 = a[2*W +: W]; r.s1 = a[3*W +: W]; end
        return r;
    endfunction

    function automatic string tag_of(logic [2:0] o);
        case (o)
            3'd0: return "R1";
            3'd1: return "R2";
            3'd2: return "R3";
            3'd3: return "R4";
            3'd4: return "R5";
            3'd5: return "R6";
            3'd6: return "R7";
            default: return "R8";
        endcase
    endfunction

    task automatic chk(string req, string what, logic [VW-1:0] act, logic [VW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic chk_all(string who, logic [2:0] o, logic [2:0] en_exp, res_t e,
                           logic [VW-1:0] v, logic [W-1:0] s0, logic [W-1:0] s1, logic [2:0] en);
        string t = tag_of(o);
        chk("R9", {who, " enables"}, VW'(en), VW'(en_exp));
        chk(en_exp[2] ? t : "R12", {who, " vector"}, v, e.v);
        chk(en_exp[1] ? t : "R12", {who, " scalar0"}, VW'(s0), VW'(e.s0));
        chk(en_exp[0] ? t : "R12", {who, " scalar1"}, VW'(s1), VW'(e.s1));
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        summary();
    end

    initial begin
        res_t e;
        logic [2:0] to, te;

        // R11: reset clears the registered outputs even with an op present
        @(negedge clk);
        vld = 1'b1; op = 3'd0; va = {4{32'h1}}; vb = {4{32'h2}};
        @(negedge clk);
        @(negedge clk);
        chk("R11", "reset outputs", {r0_v, r0_s0, r0_s1, r0_vwe, r0_swe0, r0_swe1} , '0);

        // table walk
        rst = 1'b0;
        for (int i = 0; i < NV; i++) begin
            to = TBL[i][EW-1 -: 3];
            te = TBL[i][2:0];
            op = to;
            va = TBL[i][EW-4 -: VW];
            vb = TBL[i][EW-4-VW -: VW];
            sc = TBL[i][EW-4-2*VW -: VW];
            vld = 1'b1;
            e = model(to, va, vb, sc);
            #1;
            chk_all("comb", to, te, e, r1_v, r1_s0, r1_s1, {r1_vwe, r1_swe0, r1_swe1});
            @(negedge clk);
            chk_all("reg", to, te, e, r0_v, r0_s0, r0_s1, {r0_vwe, r0_swe0, r0_swe1});
        end

        // R11: registered outputs hold until the next edge, comb follows at once
        op = 3'd7; va = 128'h44444444_33333333_22222222_11111111;
        @(negedge clk);
        op = 3'd6;
        #1;
        chk("R11", "reg holds before edge", VW'(r0_s0), VW'(32'h33333333));
        chk("R11", "comb follows inputs", VW'(r1_s0), VW'(32'h11111111));
        @(negedge clk);
        chk("R11", "reg after edge", VW'(r0_s0), VW'(32'h11111111));

        // R10: valid low silences everything
        vld = 1'b0; op = 3'd0; va = {4{32'hffff}}; vb = {4{32'h1}}; sc = '1;
        #1;
        chk("R10", "comb idle", {r1_v, r1_s0, r1_s1, r1_vwe, r1_swe0, r1_swe1}, '0);
        @(negedge clk);
        chk("R10", "reg idle", {r0_v, r0_s0, r0_s1, r0_vwe, r0_swe0, r0_swe1}, '0);

        // R11: reset mid-run clears a live result
        vld = 1'b1; op = 3'd4; va = {4{32'h10}};
        @(negedge clk);
        chk("R5", "reduce before reset", VW'(r0_s0), VW'(32'h40));
        rst = 1'b1;
        @(negedge clk);
        chk("R11", "reset clears", {r0_v, r0_s0, r0_s1, r0_vwe, r0_swe0, r0_swe1}, '0);
        rst = 1'b0;

        summary();
    end

endmodule